// File: doc/BRIEF.md
# Hessian Determinant Pipeline

This block turns the three second-derivative box-filter responses of one image point (horizontal, vertical and mixed) into a scale-normalized Hessian determinant and the sign of the Laplacian. Feature detectors use these values to score interest-point candidates. Thresholding and neighbourhood suppression happen downstream.

Each set of responses arrives with a valid strobe and its own reciprocal-area constant. The constant normalizes the responses for the filter size that produced them. The datapath is fully pipelined with a fixed latency and never stalls. A point may enter on every clock, or the points may arrive with any pattern of idle cycles in between. The valid strobe travels alongside the data and marks each result at the output.

All wide products are assembled from partial products of at most 18 by 18 bits. This keeps the arithmetic on narrow hardware multipliers.

Top module: `hessian_det_pipe`

## Requirements
- R1: While reset is asserted, out_vld is 0. After reset is released, out_vld stays 0 until a valid input has had 8 cycles to propagate.
- R2: out_vld in cycle n+8 equals in_vld sampled in cycle n, for any pattern of valid and idle cycles.
- R3: Each response is normalized as n = floor(d * A / 2^16), where A is in_inv_area read as an unsigned Q0.16 value.
- R4: The mixed term is weighted as m = floor(n_xy * WEIGHT / 2^15), with WEIGHT = 29491 by default (0.9 in Q1.15). It enters the result as m * m.
- R5: out_det = n_xx * n_yy - m * m, exact as a 49-bit two's-complement value.
- R6: out_lap_neg is 1 exactly when in_dxx + in_dyy < 0, and it leaves in the same cycle as its determinant.
- R7: in_inv_area is sampled together with each point. A new value on every cycle applies only to the point that carries it.
- R8: A new point is accepted on every clock, with no stall, when in_vld is held high continuously.
- R9: Full-scale responses (-2^23 and 2^23-1) with in_inv_area = 65535, and all-zero inputs, produce exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks a cycle that carries a point |
| in_dxx | input | 24 | Horizontal second-derivative response, signed |
| in_dyy | input | 24 | Vertical second-derivative response, signed |
| in_dxy | input | 24 | Mixed-derivative response, signed |
| in_inv_area | input | 16 | Reciprocal filter area, unsigned Q0.16 |
| out_vld | output | 1 | Marks a cycle that carries a result |
| out_det | output | 49 | Normalized determinant, signed |
| out_lap_neg | output | 1 | 1 when the trace of the point is negative |

## Verification
The assertions assume that every input is a known value in every cycle after reset, including cycles with in_vld low, because the checker's history records the trace sign and the zero pattern unconditionally. The bench drives defined random data during idle cycles and never leaves an input undriven. The assertions also assume that in_vld is low for the whole reset, so that the checker's history and the pipeline start empty together. The bench holds all inputs at zero until reset has been released.

// File: rtl/hdp_pkg.sv
`timescale 1ns/1ps
package hdp_pkg;
   // width of one hardware multiplier operand
   localparam int SLICE_W    = 18;
   // unsigned low part of a split operand
   localparam int SLICE_LO_W = SLICE_W - 1;
   // widest operand a four-slice product can take
   localparam int WIDE_W     = 2 * SLICE_W - 1;
   // width of one partial product
   localparam int PP_W       = 2 * SLICE_W;
   // register stages inside every multiplier
   localparam int MUL_LAT    = 2;

   // index of each response in the normalizer array
   localparam int IDX_XX = 0;
   localparam int IDX_YY = 1;
   localparam int IDX_XY = 2;

   typedef enum logic [0:0] {
      MUL_SINGLE = 1'b0,
      MUL_QUAD   = 1'b1
   } mul_kind_e;
endpackage

// File: rtl/hdp_delay.sv
`timescale 1ns/1ps
module hdp_delay #(
   parameter int W = 1,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("hdp_delay: W must be at least 1");
   end
   if (N < 0) begin : g_bad_n
      $error("hdp_delay: N must not be negative");
   end

   if (N == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] sr_q [N];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr_q <= '{default: '0};
         end else begin
            sr_q[0] <= d;
            for (int i = 1; i < N; i++) begin
               sr_q[i] <= sr_q[i-1];
            end
         end
      end
      assign q = sr_q[N-1];
   end
endmodule

// File: rtl/hdp_mul.sv
`timescale 1ns/1ps
module hdp_mul
   import hdp_pkg::*;
#(
   parameter int A_W = 24,
   parameter int B_W = 17,
   parameter int P_W = A_W + B_W
) (
   input  logic                  clk,
   input  logic signed [A_W-1:0] a,
   input  logic signed [B_W-1:0] b,
   output logic signed [P_W-1:0] p
);
   localparam mul_kind_e KIND = (A_W <= SLICE_W && B_W <= SLICE_W) ? MUL_SINGLE : MUL_QUAD;

   if (A_W > WIDE_W || B_W > WIDE_W) begin : g_bad_w
      $error("hdp_mul: operand wider than four slices can cover");
   end
   if (P_W < 2) begin : g_bad_p
      $error("hdp_mul: product width too small");
   end

   if (KIND == MUL_SINGLE) begin : g_single
      logic signed [P_W-1:0] p1_q, p2_q;
      always_ff @(posedge clk) begin
         p1_q <= P_W'(a) * P_W'(b);
         p2_q <= p1_q;
      end
      assign p = p2_q;
   end else begin : g_quad
      logic signed [WIDE_W-1:0]  ax, bx;
      logic signed [SLICE_W-1:0] a_lo, a_hi, b_lo, b_hi;
      logic signed [PP_W-1:0]    pll_q, plh_q, phl_q, phh_q;
      logic signed [P_W-1:0]     sum_q;

      assign ax   = WIDE_W'(a);
      assign bx   = WIDE_W'(b);
      assign a_lo = signed'({1'b0, ax[SLICE_LO_W-1:0]});
      assign b_lo = signed'({1'b0, bx[SLICE_LO_W-1:0]});
      assign a_hi = ax[WIDE_W-1:SLICE_LO_W];
      assign b_hi = bx[WIDE_W-1:SLICE_LO_W];

      // stage 1: four narrow partial products
      always_ff @(posedge clk) begin
         pll_q <= PP_W'(a_lo) * PP_W'(b_lo);
         plh_q <= PP_W'(a_lo) * PP_W'(b_hi);
         phl_q <= PP_W'(a_hi) * PP_W'(b_lo);
         phh_q <= PP_W'(a_hi) * PP_W'(b_hi);
      end

      // stage 2: weighted recombination
      always_ff @(posedge clk) begin
         sum_q <= (P_W'(phh_q) <<< (2 * SLICE_LO_W))
                + ((P_W'(plh_q) + P_W'(phl_q)) <<< SLICE_LO_W)
                + P_W'(pll_q);
      end
      assign p = sum_q;
   end
endmodule

// File: rtl/hessian_det_pipe.sv
`timescale 1ns/1ps
module hessian_det_pipe
   import hdp_pkg::*;
#(
   parameter int RESP_W = 24,
   parameter int AREA_W = 16,
   parameter int W_FRAC = 15,
   parameter int WEIGHT = 29491,
   parameter int DET_W  = 2 * RESP_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [RESP_W-1:0] in_dxx,
   input  logic signed [RESP_W-1:0] in_dyy,
   input  logic signed [RESP_W-1:0] in_dxy,
   input  logic [AREA_W-1:0]       in_inv_area,
   output logic                    out_vld,
   output logic signed [DET_W-1:0] out_det,
   output logic                    out_lap_neg
);
   localparam int AS_W = AREA_W + 1;
   localparam int WT_W = W_FRAC + 1;
   localparam int NP_W = RESP_W + AS_W;
   localparam int WP_W = RESP_W + WT_W;
   localparam int SQ_W = 2 * RESP_W;
   // input register, normalize, weight, square, subtract
   localparam int LAT  = 1 + 3 * MUL_LAT + 1;

   if (RESP_W < 2 || RESP_W > WIDE_W) begin : g_bad_resp
      $error("hessian_det_pipe: RESP_W out of range");
   end
   if (AS_W > WIDE_W || WT_W > WIDE_W) begin : g_bad_const
      $error("hessian_det_pipe: constant operand too wide");
   end
   if (WEIGHT <= 0 || WEIGHT >= (1 << W_FRAC)) begin : g_bad_weight
      $error("hessian_det_pipe: WEIGHT must lie in (0, 1)");
   end
   if (DET_W < SQ_W + 1) begin : g_bad_det
      $error("hessian_det_pipe: DET_W too narrow for the difference");
   end

   // ---------------- stage 0: input capture ----------------
   logic                     s0_vld_q, s0_lap_q;
   logic signed [RESP_W-1:0] s0_resp_q [3];
   logic [AREA_W-1:0]        s0_area_q;
   logic signed [RESP_W:0]   trace;

   assign trace = (RESP_W+1)'(in_dxx) + (RESP_W+1)'(in_dyy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_vld_q  <= 1'b0;
         s0_lap_q  <= 1'b0;
         s0_resp_q <= '{default: '0};
         s0_area_q <= '0;
      end else begin
         s0_vld_q          <= in_vld;
         s0_lap_q          <= (trace < 0);
         s0_resp_q[IDX_XX] <= in_dxx;
         s0_resp_q[IDX_YY] <= in_dyy;
         s0_resp_q[IDX_XY] <= in_dxy;
         s0_area_q         <= in_inv_area;
      end
   end

   // ---------------- normalization by reciprocal area ----------------
   logic signed [AS_W-1:0]   area_s;
   logic signed [NP_W-1:0]   nprod [3];
   logic signed [RESP_W-1:0] nrm [3];

   assign area_s = signed'({1'b0, s0_area_q});

   for (genvar g = 0; g < 3; g++) begin : g_norm
      hdp_mul #(.A_W(RESP_W), .B_W(AS_W), .P_W(NP_W)) u_mul (
         .clk (clk),
         .a   (s0_resp_q[g]),
         .b   (area_s),
         .p   (nprod[g])
      );
      assign nrm[g] = RESP_W'(nprod[g] >>> AREA_W);
   end

   // ---------------- weighting of the mixed term ----------------
   localparam logic signed [WT_W-1:0] WT_C = WT_W'(WEIGHT);
   logic signed [WP_W-1:0]   wprod;
   logic signed [RESP_W-1:0] wmix;

   hdp_mul #(.A_W(RESP_W), .B_W(WT_W), .P_W(WP_W)) u_wmul (
      .clk (clk),
      .a   (nrm[IDX_XY]),
      .b   (WT_C),
      .p   (wprod)
   );
   assign wmix = RESP_W'(wprod >>> W_FRAC);

   // diagonal terms wait while the mixed term is weighted
   logic [2*RESP_W-1:0]      diag_d;
   logic signed [RESP_W-1:0] xx_d, yy_d;

   hdp_delay #(.W(2*RESP_W), .N(MUL_LAT)) u_diag_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({nrm[IDX_XX], nrm[IDX_YY]}),
      .q     (diag_d)
   );
   assign xx_d = diag_d[2*RESP_W-1:RESP_W];
   assign yy_d = diag_d[RESP_W-1:0];

   // ---------------- products ----------------
   logic signed [SQ_W-1:0] pdiag, pmix;

   hdp_mul #(.A_W(RESP_W), .B_W(RESP_W), .P_W(SQ_W)) u_pdiag (
      .clk (clk),
      .a   (xx_d),
      .b   (yy_d),
      .p   (pdiag)
   );
   hdp_mul #(.A_W(RESP_W), .B_W(RESP_W), .P_W(SQ_W)) u_pmix (
      .clk (clk),
      .a   (wmix),
      .b   (wmix),
      .p   (pmix)
   );

   // ---------------- difference ----------------
   logic signed [DET_W-1:0] det_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q <= '0;
      end else begin
         det_q <= DET_W'(pdiag) - DET_W'(pmix);
      end
   end
   assign out_det = det_q;

   // ---------------- side-band: valid and trace sign ----------------
   hdp_delay #(.W(1), .N(LAT-1)) u_vld_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (s0_vld_q),
      .q     (out_vld)
   );
   hdp_delay #(.W(1), .N(LAT-1)) u_lap_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (s0_lap_q),
      .q     (out_lap_neg)
   );
endmodule

// File: rtl/hessian_det_chk.sv
`timescale 1ns/1ps
module hessian_det_chk #(
   parameter int RESP_W = 24,
   parameter int DET_W  = 49,
   parameter int LAT    = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_vld,
   input logic signed [RESP_W-1:0] in_dxx,
   input logic signed [RESP_W-1:0] in_dyy,
   input logic signed [RESP_W-1:0] in_dxy,
   input logic                    out_vld,
   input logic signed [DET_W-1:0] out_det,
   input logic                    out_lap_neg
);
   logic [LAT-1:0] vld_h, lap_h, zero_h;
   logic           lap_now, zero_now;

   assign lap_now  = (longint'(in_dxx) + longint'(in_dyy)) < 0;
   assign zero_now = (in_dxy == '0) && ((in_dxx == '0) || (in_dyy == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_h  <= '0;
         lap_h  <= '0;
         zero_h <= '0;
      end else begin
         vld_h  <= {vld_h[LAT-2:0], in_vld};
         lap_h  <= {lap_h[LAT-2:0], lap_now};
         zero_h <= {zero_h[LAT-2:0], zero_now};
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_vld);

   // R2
   vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == vld_h[LAT-1]);

   // R6
   lap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_lap_neg == lap_h[LAT-1]));

   // R5
   zero_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && zero_h[LAT-1]) |-> (out_det == '0));

   // R5
   det_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !$isunknown(out_det));
endmodule

bind hessian_det_pipe hessian_det_chk #(
   .RESP_W (RESP_W),
   .DET_W  (DET_W),
   .LAT    (LAT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_vld      (in_vld),
   .in_dxx      (in_dxx),
   .in_dyy      (in_dyy),
   .in_dxy      (in_dxy),
   .out_vld     (out_vld),
   .out_det     (out_det),
   .out_lap_neg (out_lap_neg)
);

// File: tb/sim_hessian_det_pipe.sv
`timescale 1ns/1ps
module sim_hessian_det_pipe;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 8;
   localparam longint WGT    = 29491;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic in_vld = 1'b0;
   logic signed [23:0] in_dxx = '0, in_dyy = '0, in_dxy = '0;
   logic [15:0] in_inv_area = '0;
   logic out_vld;
   logic signed [48:0] out_det;
   logic out_lap_neg;

   always #(CLK_PERIOD/2) clk = ~clk;

   hessian_det_pipe u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .in_dxx(in_dxx), .in_dyy(in_dyy), .in_dxy(in_dxy),
      .in_inv_area(in_inv_area),
      .out_vld(out_vld), .out_det(out_det), .out_lap_neg(out_lap_neg)
   );

   typedef struct {
      bit     v;
      longint det;
      bit     lap;
      string  tag;
   } exp_t;

   exp_t exp_q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   function automatic logic signed [23:0] rnd24();
      return 24'($urandom);
   endfunction

   function automatic longint fl_shift(input longint x, input int s);
      return x >>> s;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   // one clock: compare the result due now, then drive the next point
   task automatic step(input bit v, input logic signed [23:0] xx, input logic signed [23:0] yy,
                       input logic signed [23:0] xy, input logic [15:0] ar, input string tag);
      exp_t e;
      longint nxx, nyy, nxy, m;
      @(negedge clk);
      if (exp_q.size() == LAT) begin
         e = exp_q.pop_front();
         check(out_vld == e.v, "R2", longint'(out_vld), longint'(e.v));
         if (e.v) begin
            check(longint'(out_det) == e.det, e.tag, longint'(out_det), e.det);
            check(out_lap_neg == e.lap, "R6", longint'(out_lap_neg), longint'(e.lap));
         end
      end else begin
         check(out_vld == 1'b0, "R1", longint'(out_vld), 0);
      end
      in_vld = v; in_dxx = xx; in_dyy = yy; in_dxy = xy; in_inv_area = ar;
      nxx = fl_shift(longint'(xx) * longint'(ar), 16);
      nyy = fl_shift(longint'(yy) * longint'(ar), 16);
      nxy = fl_shift(longint'(xy) * longint'(ar), 16);
      m   = fl_shift(nxy * WGT, 15);
      e.v   = v;
      e.det = nxx * nyy - m * m;
      e.lap = (longint'(xx) + longint'(yy)) < 0;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2: watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      // R1: quiet during reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(out_vld == 1'b0, "R1", longint'(out_vld), 0);
      end
      rst_n = 1'b1;

      // R8: back-to-back points
      for (int i = 0; i < 40; i++)
         step(1, rnd24(), rnd24(), rnd24(), 16'($urandom), "R8");
      // R3: no mixed term, result is the normalized diagonal product
      for (int i = 0; i < 20; i++)
         step(1, rnd24(), rnd24(), 24'sd0, 16'($urandom), "R3");
      // R4: only the weighted mixed term contributes
      for (int i = 0; i < 20; i++)
         step(1, 24'sd0, rnd24(), rnd24(), 16'($urandom), "R4");
      // R5: irregular arrival, fixed scale
      for (int i = 0; i < 60; i++)
         step(1'($urandom), rnd24(), rnd24(), rnd24(), 16'd16384, "R5");
      // R7: scale changes on every cycle
      for (int i = 0; i < 60; i++)
         step(1'($urandom), rnd24(), rnd24(), rnd24(), 16'($urandom), "R7");
      // R6: small responses around a zero trace
      for (int i = 0; i < 30; i++)
         step(1, 24'(int'($urandom % 9) - 4), 24'(int'($urandom % 9) - 4),
              24'(int'($urandom % 5) - 2), 16'hFFFF, "R6");
      step(1, 24'sd5, -24'sd5, 24'sd0, 16'hFFFF, "R6");
      // R9: full-scale and zero corners
      step(1, -24'sd8388608, -24'sd8388608, -24'sd8388608, 16'hFFFF, "R9");
      step(1, 24'sd8388607, 24'sd8388607, 24'sd8388607, 16'hFFFF, "R9");
      step(1, 24'sd8388607, -24'sd8388608, -24'sd8388608, 16'hFFFF, "R9");
      step(1, 24'sd0, 24'sd0, 24'sd0, 16'hFFFF, "R9");
      step(1, 24'sd0, 24'sd0, -24'sd8388608, 16'hFFFF, "R9");
      step(1, -24'sd8388608, 24'sd8388607, 24'sd0, 16'h0000, "R9");
      // drain
      for (int i = 0; i < LAT + 2; i++)
         step(0, '0, '0, '0, '0, "R2");

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule